// File: doc/BRIEF.md
# Grayscale OLED Segment Phase Timing Generator

This block produces the per-row drive timing for the column (segment) outputs of a grayscale OLED panel driver. An input clock is divided into a display clock tick, and a row counter advances once per tick through a programmable number of display clocks per row. Within every row each column goes through three phases in fixed order: a discharge phase with no drive, a precharge phase, and a current-on phase whose length sets the pixel's brightness. After the on phase the column returns to no drive until the row ends.

The on-phase length for each column comes from that column's 4-bit gray level. Each level has a fixed base length. A programmable 3-bit offset per level is added to it. Level 0 never drives current. A global display mode can replace every level with full brightness, with black, or with its inverse. A display-off state keeps every column undriven.

Pixel levels arrive on a flat column-indexed input. A one-cycle row-start pulse marks each row boundary for an external row counter. Configuration is written through a small address/data write port.

Top module: `oled_phase_gen`

## Requirements
- R1: After reset: display off, all columns at code 00, discharge length 3, precharge length 5, row period 37 display clocks, divide ratio 3, normal mode, and every table offset equal to 1.
- R2: Writing value d to address 2 sets the divide ratio to d[3:0]+1. A display clock tick then occurs every d[3:0]+1 input clocks, so row_start pulses are ratio × row-period input clocks apart.
- R3: Each column outputs 2-bit phase codes: 00 for no drive, 01 for precharge, 10 for current on. Code 11 is never produced. Counting display clocks k from 0 in a row, the code is 00 for k < P1, 01 for P1 ≤ k < P1+P2, 10 for P1+P2 ≤ k < P1+P2+P3, and 00 after that. P1 is bits 3:0 and P2 is bits 7:4 of address 0.
- R4: P3 is 0 for an effective level of 0. For any other effective level L it is 2·(L−1) plus the table offset of L.
- R5: A write to address 8 sets the offset of level 1 from bits 2:0. A write to address 8+k (k = 1..7) sets level 2k from bits 2:0 and level 2k+1 from bits 6:4.
- R6: Address 1 holds the row period. Address 3 bits 1:0 select the mode: 0 normal (level used as given), 1 all-on (level 15), 2 all-off (level 0), 3 inverse (15 − level).
- R7: While address 4 bit 0 is 0, every column outputs 00. Writing 1 there enables drive.
- R8: If P1+P2+P3 exceeds the row period, the on phase is cut off at the row end and the next row starts again with code 00 in its discharge phase.
- R9: A row period value below 2 acts as 2.
- R10: row_start is high for exactly one input clock in each row: the clock on which the last display clock of the row ends. The next display clock is k = 0 of the new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| pix_level | input | NCOL*4 | Gray level of column c in bits 4c+3:4c |
| seg_phase | output | NCOL*2 | Phase code of column c in bits 2c+1:2c |
| row_start | output | 1 | One-clock pulse at each row boundary |

## Verification
The assertions check on every cycle that display-off and all-off mode never produce current drive. They also check that code 11 never appears, that the row counter restarts right after a row_start, and that no column falls back from the on phase to precharge within a row. Only the bench scenarios can show the exact phase boundaries for each gray level and mode. They also show the effect of table writes on particular levels, the row and divide spacing of row_start, clamping of short row periods, and truncation of an on phase at the row end.

// File: rtl/oled_phase_gen.sv
module oled_phase_gen #(
  parameter int NCOL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [NCOL*4-1:0] pix_level,
  output logic [NCOL*2-1:0] seg_phase,
  output logic              row_start
);
  localparam logic [1:0] PH_OFF = 2'b00, PH_PRE = 2'b01, PH_ON = 2'b10;

  logic [7:0] phase_r, period_r, dcnt, last;
  logic [3:0] div_r, div_cnt;
  logic [1:0] mode_r;
  logic       disp_on, tick;
  logic [2:0] gtab [1:15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_r  <= 8'h53;
      period_r <= 8'h25;
      div_r    <= 4'h2;
      mode_r   <= 2'd0;
      disp_on  <= 1'b0;
      for (int i = 1; i < 16; i++) gtab[i] <= 3'd1;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: phase_r  <= cfg_wdata;
        4'd1: period_r <= cfg_wdata;
        4'd2: div_r    <= cfg_wdata[3:0];
        4'd3: mode_r   <= cfg_wdata[1:0];
        4'd4: disp_on  <= cfg_wdata[0];
        4'd8: gtab[1]  <= cfg_wdata[2:0];
        default:
          if (cfg_addr[3]) begin
            gtab[{cfg_addr[2:0], 1'b0}] <= cfg_wdata[2:0];
            gtab[{cfg_addr[2:0], 1'b1}] <= cfg_wdata[6:4];
          end
      endcase
    end
  end

  assign last      = (period_r < 8'd2) ? 8'd1 : period_r - 8'd1;
  assign tick      = div_cnt >= div_r;
  assign row_start = tick && dcnt >= last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      dcnt    <= '0;
    end else begin
      div_cnt <= tick ? 4'd0 : div_cnt + 4'd1;
      if (tick) dcnt <= (dcnt >= last) ? 8'd0 : dcnt + 8'd1;
    end
  end

  logic [7:0] b1, b2;
  assign b1 = {4'd0, phase_r[3:0]};
  assign b2 = b1 + {4'd0, phase_r[7:4]};

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [3:0] lvl, eff;
    logic [7:0] b3;
    assign lvl = pix_level[4*c +: 4];
    always_comb begin
      case (mode_r)
        2'd1:    eff = 4'd15;
        2'd2:    eff = 4'd0;
        2'd3:    eff = 4'd15 - lvl;
        default: eff = lvl;
      endcase
      if (eff == 4'd0) b3 = b2;
      else             b3 = b2 + {3'd0, eff - 4'd1, 1'b0} + {5'd0, gtab[eff]};
    end
    assign seg_phase[2*c +: 2] = !disp_on ? PH_OFF :
                                 (dcnt < b1) ? PH_OFF :
                                 (dcnt < b2) ? PH_PRE :
                                 (dcnt < b3) ? PH_ON  : PH_OFF;
  end
endmodule

// File: rtl/oled_phase_gen_chk.sv
module oled_phase_gen_chk #(
  parameter int NCOL = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [NCOL*2-1:0] seg_phase,
  input logic              row_start,
  input logic              disp_on,
  input logic [1:0]        mode_r,
  input logic [7:0]        dcnt
);
  p_dark_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> seg_phase == '0);

  p_row_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> dcnt == 8'd0);

  for (genvar c = 0; c < NCOL; c++) begin : g_c
    p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_phase[2*c +: 2] != 2'b11);

    p_alloff_noon_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_r == 2'd2 |-> seg_phase[2*c +: 2] != 2'b10);

    p_on_no_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_phase[2*c +: 2] == 2'b10 && !row_start && !cfg_we)
        |=> seg_phase[2*c +: 2] != 2'b01);
  end
endmodule

bind oled_phase_gen oled_phase_gen_chk #(.NCOL(NCOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .seg_phase(seg_phase),
  .row_start(row_start), .disp_on(disp_on), .mode_r(mode_r), .dcnt(dcnt)
);

// File: tb/oled_phase_gen_test.sv
module oled_phase_gen_test;
  localparam int NCOL = 8;
  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [NCOL*4-1:0] pix_level = '0;
  logic [NCOL*2-1:0] seg_phase;
  logic row_start;

  oled_phase_gen #(.NCOL(NCOL)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, p1 = 3, p2 = 5, per = 37, mode = 0;
  bit dsp = 0, done = 0;
  int tbl [16];

  // vector: mode[21:20] base[19:16] p1[15:12] p2[11:8] period[7:0]
  localparam logic [21:0] VEC [6] = '{
    {2'd0, 4'd0,  4'd3, 4'd5, 8'd40},
    {2'd0, 4'd9,  4'd1, 4'd2, 8'd50},
    {2'd1, 4'd4,  4'd2, 4'd2, 8'd45},
    {2'd2, 4'd7,  4'd4, 4'd1, 8'd20},
    {2'd3, 4'd2,  4'd2, 4'd3, 8'd48},
    {2'd0, 4'd12, 4'd6, 4'd7, 8'd30}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic int exp_code(input int k, input int lvl);
    int e, p3;
    e = (mode == 1) ? 15 : (mode == 2) ? 0 : (mode == 3) ? 15 - lvl : lvl;
    p3 = (e == 0) ? 0 : 2 * (e - 1) + tbl[e];
    if (!dsp || k < p1) return 0;
    if (k < p1 + p2) return 1;
    if (k < p1 + p2 + p3) return 2;
    return 0;
  endfunction

  task automatic sync_row();
    do @(negedge clk); while (!row_start);
  endtask

  task automatic check_row(input string req);
    int bad = 0, ba = 0, be = 0, rs_bad = 0;
    sync_row();
    for (int k = 0; k < per; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCOL; c++) begin
        int a, e;
        a = seg_phase[2*c +: 2];
        e = exp_code(k, pix_level[4*c +: 4]);
        if (a != e && bad == 0) begin ba = a; be = e; end
        if (a != e) bad++;
      end
      if (row_start != (k == per - 1)) rs_bad++;
    end
    chk(bad == 0, req, ba, be);
    chk(rs_bad == 0, "R10 row_start single pulse", rs_bad, 0);
  endtask

  task automatic gap(output int n);
    sync_row();
    n = 0;
    do begin @(negedge clk); n++; end while (!row_start);
  endtask

  task automatic set_pix(input int base, input int step);
    for (int c = 0; c < NCOL; c++) pix_level[4*c +: 4] = 4'((base + step * c) % 16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) tbl[i] = 1;
    set_pix(1, 2);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(seg_phase == '0, "R1 reset all columns off", int'(seg_phase), 0);
    gap(n);
    chk(n == 111, "R1/R2 default row spacing", n, 111);

    wr(2, 8'h00);
    wr(4, 8'h01); dsp = 1;
    check_row("R1 default phases and offsets");

    foreach (VEC[i]) begin
      mode = VEC[i][21:20]; p1 = VEC[i][15:12]; p2 = VEC[i][11:8]; per = VEC[i][7:0];
      wr(0, {VEC[i][11:8], VEC[i][15:12]});
      wr(1, VEC[i][7:0]);
      wr(3, {6'd0, VEC[i][21:20]});
      set_pix(VEC[i][19:16], 3);
      check_row(i == 5 ? "R8 truncated on phase" : "R3/R4/R6 vector row");
    end

    mode = 0; wr(3, 8'h00);
    wr(8, 8'h05);  tbl[1] = 5;
    wr(9, 8'h73);  tbl[2] = 3; tbl[3] = 7;
    wr(15, 8'h26); tbl[14] = 6; tbl[15] = 2;
    p1 = 2; p2 = 1; per = 60;
    wr(0, 8'h12); wr(1, 8'd60);
    pix_level = {4'd15, 4'd14, 4'd3, 4'd2, 4'd1, 4'd0, 4'd15, 4'd1};
    check_row("R5 table write positions");

    wr(4, 8'h00); dsp = 0;
    check_row("R7 display off forces no drive");
    wr(4, 8'h01); dsp = 1;

    wr(1, 8'd10); wr(2, 8'h03);
    gap(n);
    chk(n == 40, "R2 divide ratio 4 row spacing", n, 40);
    wr(2, 8'h00);

    wr(1, 8'd0);
    gap(n);
    chk(n == 2, "R9 row period 0 acts as 2", n, 2);
    wr(1, 8'd1);
    gap(n);
    chk(n == 2, "R9 row period 1 acts as 2", n, 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule